// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen architectural general registers of a processor core. Which physical storage cell a register number reaches depends on the current processor mode. Registers 0 to 12 carry data, 13 is the stack pointer, 14 is the link register and 15 is the program counter. The program counter and the current status word live outside the block. A read of register 15 returns the external pc value plus 8. A write to register 15 is handed straight to a pc-write output and does not reach the array.

The fast interrupt mode has private copies of registers 8 through 14. The normal interrupt, supervisor, abort and undefined modes each have private copies of only 13 and 14. Each of these five exception modes also owns a saved status register. User and system modes share one bank and have no saved status register.

The block has two combinational read ports and one clocked write port. An exception-entry port deposits the return address and the saved status word into the target mode's registers in a single cycle. A user-view input lets privileged code reach the user-bank copies.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register and every saved status register reads as zero.
- R2: The mode input is encoded as 0 user, 1 fast interrupt, 2 normal interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system, with 7 behaving as user. In modes 0, 6 and 7, registers 0 to 14 all use the one user bank.
- R3: In fast interrupt mode, registers 8 to 14 are private copies. Registers 0 to 7 are shared with the user bank.
- R4: In modes 2 to 5, each mode has private copies of registers 13 and 14. Registers 0 to 12 are shared with the user bank.
- R5: On either read port, register number 15 returns pc_in + 8, modulo 2^32.
- R6: A write to register 15 drives pc_wr_en high and pc_wr_data equal to wr_data in that same cycle. It changes no stored register. Writes to 0 to 14 keep pc_wr_en low.
- R7: Reads are combinational and a write takes effect at the rising clock edge. In the write cycle itself, a read of the register being written returns the old value.
- R8: Modes 1 to 5 each have their own saved status register, which spsr_rdata shows and spsr_we writes at the clock edge. In modes 0, 6 and 7, spsr_rdata is zero and spsr_we has no effect.
- R9: With exc_en high and exc_mode in 1 to 5, the clock edge writes exc_lr into register 14 of exc_mode and exc_psr into that mode's saved status register, whatever the current mode is. This write takes priority over a port write to the same cell in the same cycle. With exc_mode outside 1 to 5, exc_en does nothing.
- R10: With usr_en high, both read ports and the write port use the user bank whatever the mode. The saved status access still follows the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current processor mode |
| usr_en | input | 1 | Force register ports to the user bank |
| pc_in | input | 32 | Address of the current instruction |
| ra_addr | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| pc_wr_en | output | 1 | Write to register 15 requested |
| pc_wr_data | output | 32 | Value written to register 15 |
| spsr_we | input | 1 | Saved status write enable for current mode |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status register of current mode |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 3 | Mode being entered |
| exc_lr | input | 32 | Return address for the target link register |
| exc_psr | input | 32 | Status word for the target saved status register |

## Verification
A wrong bank selection shows up as a cross-mode alias: a value written in one mode appears when the same register number is read in another mode. This is visible on the read ports in the first cycle after the write edge. A broken exception-entry or priority path leaves a stale link register or saved status word, visible on the very next read. The bench writes a unique value into every register in every mode and then reads all of them back, so any aliasing or lost write shows at a port.

// File: rtl/banked_regfile.sv
module banked_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        usr_en,
  input  logic [31:0] pc_in,
  input  logic [3:0]  ra_addr,
  output logic [31:0] ra_data,
  input  logic [3:0]  rb_addr,
  output logic [31:0] rb_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        pc_wr_en,
  output logic [31:0] pc_wr_data,
  input  logic        spsr_we,
  input  logic [31:0] spsr_wdata,
  output logic [31:0] spsr_rdata,
  input  logic        exc_en,
  input  logic [2:0]  exc_mode,
  input  logic [31:0] exc_lr,
  input  logic [31:0] exc_psr
);
  localparam int NPHYS = 31;
  localparam int NSPSR = 5;

  logic [31:0] gpr  [NPHYS];
  logic [31:0] spsr [NSPSR];

  function automatic logic [4:0] phys(input logic [2:0] m, input logic [3:0] r);
    if (m == 3'd1 && r >= 4'd8)
      return 5'({1'b0, r} + 5'd8);
    if (m >= 3'd2 && m <= 3'd5 && r >= 4'd13)
      return 5'(5'd23 + 5'({m - 3'd2, 1'b0}) + 5'({1'b0, r} - 5'd13));
    return {1'b0, r};
  endfunction

  function automatic logic is_exc(input logic [2:0] m);
    return m >= 3'd1 && m <= 3'd5;
  endfunction

  logic [2:0] emode;
  logic [4:0] pa, pb, pw, plr;
  logic [2:0] sidx, eidx;
  logic       gw, ew;

  assign emode = usr_en ? 3'd0 : mode;
  assign pa    = phys(emode, ra_addr);
  assign pb    = phys(emode, rb_addr);
  assign pw    = phys(emode, wr_addr);
  assign plr   = phys(exc_mode, 4'd14);
  assign sidx  = mode - 3'd1;
  assign eidx  = exc_mode - 3'd1;
  assign gw    = wr_en && wr_addr != 4'd15;
  assign ew    = exc_en && is_exc(exc_mode);

  assign ra_data    = (ra_addr == 4'd15) ? pc_in + 32'd8 : gpr[pa];
  assign rb_data    = (rb_addr == 4'd15) ? pc_in + 32'd8 : gpr[pb];
  assign pc_wr_en   = wr_en && wr_addr == 4'd15;
  assign pc_wr_data = wr_data;
  assign spsr_rdata = is_exc(mode) ? spsr[sidx] : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) gpr[i] <= '0;
      for (int i = 0; i < NSPSR; i++) spsr[i] <= '0;
    end else begin
      if (gw) gpr[pw] <= wr_data;
      if (spsr_we && is_exc(mode)) spsr[sidx] <= spsr_wdata;
      if (ew) begin
        gpr[plr]   <= exc_lr;
        spsr[eidx] <= exc_psr;
      end
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode,
  input logic        usr_en,
  input logic [31:0] pc_in,
  input logic [3:0]  ra_addr,
  input logic [31:0] ra_data,
  input logic [3:0]  rb_addr,
  input logic [31:0] rb_data,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        pc_wr_en,
  input logic [31:0] pc_wr_data,
  input logic [31:0] spsr_rdata,
  input logic        exc_en,
  input logic [2:0]  exc_mode,
  input logic [31:0] exc_lr,
  input logic [31:0] exc_psr
);
  assert_pc_read_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ra_addr == 4'd15 |-> ra_data == pc_in + 32'd8);
  assert_pc_read_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_addr == 4'd15 |-> rb_data == pc_in + 32'd8);
  assert_pc_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd15) |-> (pc_wr_en && pc_wr_data == wr_data));
  assert_no_pc_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 4'd15) |-> !pc_wr_en);
  assert_spsr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode >= 3'd6) |-> spsr_rdata == 32'd0);
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 4'd15 && !exc_en) |=>
      ((ra_addr == $past(wr_addr) && mode == $past(mode) && usr_en == $past(usr_en))
        -> ra_data == $past(wr_data)));
  assert_exc_lr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && exc_mode >= 3'd1 && exc_mode <= 3'd5) |=>
      ((mode == $past(exc_mode) && !usr_en && ra_addr == 4'd14) -> ra_data == $past(exc_lr)));
  assert_exc_psr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && exc_mode >= 3'd1 && exc_mode <= 3'd5) |=>
      (mode == $past(exc_mode) -> spsr_rdata == $past(exc_psr)));
endmodule

bind banked_regfile banked_regfile_chk chk_i (.*);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  mode = 0;
  logic        usr_en = 0;
  logic [31:0] pc_in = 0;
  logic [3:0]  ra_addr = 0, rb_addr = 0, wr_addr = 0;
  logic [31:0] ra_data, rb_data, wr_data = 0, pc_wr_data, spsr_rdata;
  logic        wr_en = 0, pc_wr_en, spsr_we = 0, exc_en = 0;
  logic [31:0] spsr_wdata = 0, exc_lr = 0, exc_psr = 0;
  logic [2:0]  exc_mode = 0;

  int vectors = 0, miscompares = 0;
  logic [31:0] mexp [8][15];
  logic [31:0] sexp [8];

  always #4 clk = ~clk;

  banked_regfile dut_i (.*);

  function automatic int bank(input int m, input int r);
    if (m == 1 && r >= 8) return 1;
    if (m >= 2 && m <= 5 && r >= 13) return m;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input int m, input int r, input logic [31:0] v);
    for (int k = 0; k < 8; k++) if (bank(k, r) == bank(m, r)) mexp[k][r] = v;
  endtask

  task automatic wr(input int m, input int r, input logic [31:0] v);
    @(negedge clk);
    mode = 3'(m); wr_en = 1; wr_addr = 4'(r); wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sweep(input string tag);
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 15; r++) begin
        @(negedge clk);
        mode = 3'(m); ra_addr = 4'(r); rb_addr = 4'(14 - r);
        #1;
        check(tag, ra_data, mexp[m][r]);
        check(tag, rb_data, mexp[m][14 - r]);
      end
      check({tag, " spsr"}, spsr_rdata, sexp[m]);
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      sexp[m] = 0;
      for (int r = 0; r < 15; r++) mexp[m][r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1 reset");

    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 15; r++) begin
        wr(m, r, 32'hA000_0000 | (m << 8) | r);
        model_wr(m, r, 32'hA000_0000 | (m << 8) | r);
      end
    sweep("R2 R3 R4 banking");

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pc_in = 32'hFFFF_FFF0 + 32'(i * 4) - 32'(i * 32'h1000);
      ra_addr = 15; rb_addr = 15; mode = 3'(i);
      #1;
      check("R5 pc read a", ra_data, pc_in + 32'd8);
      check("R5 pc read b", rb_data, pc_in + 32'd8);
    end

    @(negedge clk);
    mode = 1; wr_en = 1; wr_addr = 15; wr_data = 32'h1234_5678;
    #1;
    check("R6 pc_wr_en", {31'd0, pc_wr_en}, 32'd1);
    check("R6 pc_wr_data", pc_wr_data, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1; wr_addr = 9; wr_data = 32'h0;
    #1;
    check("R6 no pc_wr_en", {31'd0, pc_wr_en}, 32'd0);
    model_wr(1, 9, 32'h0);
    @(negedge clk);
    wr_en = 0;
    sweep("R6 array untouched");

    @(negedge clk);
    mode = 3; ra_addr = 3; wr_en = 1; wr_addr = 3; wr_data = 32'hCAFE_0003;
    #1;
    check("R7 old value", ra_data, mexp[3][3]);
    @(negedge clk);
    wr_en = 0;
    #1;
    check("R7 new value", ra_data, 32'hCAFE_0003);
    model_wr(3, 3, 32'hCAFE_0003);

    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      mode = 3'(m); spsr_we = 1; spsr_wdata = 32'h5500_0000 | m;
      if (m >= 1 && m <= 5) sexp[m] = 32'h5500_0000 | m;
    end
    @(negedge clk);
    spsr_we = 0;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      mode = 3'(m);
      #1;
      check("R8 spsr", spsr_rdata, sexp[m]);
    end

    @(negedge clk);
    mode = 0; exc_en = 1; exc_mode = 4; exc_lr = 32'h0000_4444; exc_psr = 32'h0000_00D7;
    @(negedge clk);
    mode = 3; exc_mode = 3; exc_lr = 32'h0000_3333; exc_psr = 32'h0000_00D3;
    wr_en = 1; wr_addr = 14; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    mode = 0; exc_mode = 6; exc_lr = 32'hBAD0_0006; exc_psr = 32'hBAD0_0006; wr_en = 0;
    @(negedge clk);
    exc_en = 0;
    model_wr(4, 14, 32'h0000_4444); sexp[4] = 32'h0000_00D7;
    model_wr(3, 14, 32'h0000_3333); sexp[3] = 32'h0000_00D3;
    sweep("R9 exception entry");

    @(negedge clk);
    mode = 1; usr_en = 1;
    for (int r = 0; r < 15; r++) begin
      @(negedge clk);
      ra_addr = 4'(r);
      #1;
      check("R10 user view read", ra_data, mexp[0][r]);
    end
    check("R10 spsr follows mode", spsr_rdata, sexp[1]);
    @(negedge clk);
    mode = 2; wr_en = 1; wr_addr = 13; wr_data = 32'h0BAD_F00D;
    @(negedge clk);
    wr_en = 0; usr_en = 0;
    model_wr(0, 13, 32'h0BAD_F00D);
    sweep("R10 user view write");

    @(negedge clk);
    rst_n = 0;
    for (int m = 0; m < 8; m++) begin
      sexp[m] = 0;
      for (int r = 0; r < 15; r++) mexp[m][r] = 0;
    end
    @(negedge clk);
    rst_n = 1;
    sweep("R1 second reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule